// File: doc/BRIEF.md
# Square Tone Channel with Waveform Restart

This block produces one square-wave voice for a retro sound generator. A programmable down-counting divider, advanced on every second system clock, emits a step pulse once per period. Each step pulse moves an 8-position waveform sequencer forward. The sequencer position selects one bit from one of four duty patterns. When that bit is set, a 4-bit volume word is placed on the sample output. One sample leaves the block on every clock.

The CPU programs the channel through a byte-wide write port with a strobe, a 2-bit address and 8 data bits. A write to the period-high address restarts the waveform at position 0. The divider keeps its current count, so software can place the waveform restart anywhere within a divider period. A period below 8 silences the voice, but the divider and the sequencer keep running underneath.

Top module: `sqch_top`

## Requirements
- R1: A synchronous active-high reset clears the divider, the prescaler, the sequencer position and all programmed fields to zero. The sample output is 0 after reset and stays 0 until the channel is programmed.
- R2: Register decode is as follows. Address 0 holds the duty select in data bits 7:6 and the volume in bits 3:0. Address 2 holds period bits 7:0. Address 3 holds period bits 10:8 in data bits 2:0, and its bits 7:3 are ignored. A write to address 1 has no effect.
- R3: The divider counts on every second clock. It reaches zero, and then reloads, once every (period+1)*2 clocks, and each time it does the sequencer advances one position. A period of 0x81 gives one advance every 260 clocks.
- R4: The sequencer has 8 positions and wraps from 7 back to 0. Four advances therefore shift the waveform by half a cycle.
- R5: Position p reads bit p of the selected pattern. Bit 0 is the first position. Duty 0 is high only at position 1. Duty 1 is high at positions 1 and 2. Duty 2 is high at positions 1 to 4, which is 50 %. Duty 3 is high at positions 0 and 3 to 7.
- R6: The sample output is registered. It equals the volume field when the selected pattern bit is 1 and the channel is not muted, and 0 otherwise.
- R7: A write to address 3 returns the sequencer to position 0 and leaves the divider count untouched.
- R8: The divider is loaded from the period field only when it underflows. No register write reloads it, clears it or holds it.
- R9: While the period is below 8, the sample output is 0, and the divider and sequencer keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| sample | output | 4 | Registered audio sample |

## Verification
The hardest case to reach is the proof that a waveform restart leaves the divider alone. That means observing when a restart takes effect relative to a divider underflow that was scheduled before the restart. The bench first holds the period at 0, so the divider sits at zero and re-arms on the next prescaler tick. A low-byte write of 200 then starts a long period from a known edge. About 300 clocks later the restart write arrives. The first high sample must then come roughly 100 clocks later, at the pending underflow. A restart that also reloaded the divider would push it out to about 402 clocks.

// File: rtl/sqch_pkg.sv
package sqch_pkg;
  localparam int SEQ_STEPS = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PLO  = 2'd2;
  localparam logic [1:0] ADDR_PHI  = 2'd3;

  // Pattern bit p is read at sequencer position p.
  function automatic logic [SEQ_STEPS-1:0] duty_pattern(input logic [1:0] sel);
    case (sel)
      2'd0:    duty_pattern = 8'b0000_0010;
      2'd1:    duty_pattern = 8'b0000_0110;
      2'd2:    duty_pattern = 8'b0001_1110;
      default: duty_pattern = 8'b1111_1001;
    endcase
  endfunction
endpackage

// File: rtl/sqch_regs.sv
module sqch_regs
  import sqch_pkg::*;
#(
  parameter int PER_W = 11,
  parameter int VOL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [1:0]       duty,
  output logic [VOL_W-1:0] vol,
  output logic [PER_W-1:0] period,
  output logic             restart
);
  localparam int HI_W = PER_W - 8;

  logic [1:0]       duty_q;
  logic [VOL_W-1:0] vol_q;
  logic [7:0]       plo_q;
  logic [HI_W-1:0]  phi_q;

  assign restart = wr_en && (wr_addr == ADDR_PHI);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      vol_q  <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          duty_q <= wr_data[7:6];
          vol_q  <= wr_data[VOL_W-1:0];
        end
        ADDR_PLO: plo_q <= wr_data;
        ADDR_PHI: phi_q <= wr_data[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign duty   = duty_q;
  assign vol    = vol_q;
  assign period = {phi_q, plo_q};

  // R2: a write to address 1 leaves every field as it was
  a_r2_addr1_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd1) |=> ($stable(period) && $stable(vol) && $stable(duty)));
endmodule

// File: rtl/sqch_timer.sv
module sqch_timer #(
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             step
);
  logic             half_q;
  logic [PER_W-1:0] cnt_q;
  logic             tick;

  assign tick = half_q;
  assign step = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= ~half_q;
  end

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (step)       cnt_q <= period;
    else if (tick)       cnt_q <= cnt_q - 1'b1;
  end

  // R3: the prescaler enable alternates every clock
  a_r3_tick_alternates: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R8: the count only decrements away from underflow
  a_r8_decrement_only: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q != '0) |=> (cnt_q == PER_W'($past(cnt_q) - 1'b1)));
  // R8: the count holds between ticks, whatever is written
  a_r8_hold_off_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R8: an underflow loads the period value
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == $past(period)));
endmodule

// File: rtl/sqch_seq.sv
module sqch_seq
  import sqch_pkg::*;
#(
  parameter int STEP_W = $clog2(SEQ_STEPS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       restart,
  input  logic [1:0] duty,
  output logic       wave_bit
);
  logic [STEP_W-1:0]    pos_q;
  logic [SEQ_STEPS-1:0] pat;

  always_ff @(posedge clk) begin
    if (rst)          pos_q <= '0;
    else if (restart) pos_q <= '0;
    else if (adv)     pos_q <= pos_q + 1'b1;
  end

  assign pat      = duty_pattern(duty);
  assign wave_bit = pat[pos_q];

  // R7: a restart lands on position 0
  a_r7_restart_pos0: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pos_q == '0));
  // R4: an advance moves exactly one position, wrapping after 7
  a_r4_advance_one: assert property (@(posedge clk) disable iff (rst)
    (adv && !restart) |=> (pos_q == STEP_W'($past(pos_q) + 1'b1)));
  // R4: no movement without an advance or restart
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !restart) |=> $stable(pos_q));
endmodule

// File: rtl/sqch_top.sv
module sqch_top
  import sqch_pkg::*;
#(
  parameter int PER_W    = 11,
  parameter int VOL_W    = 4,
  parameter int MUTE_MIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [VOL_W-1:0] sample
);
  logic [1:0]       duty;
  logic [VOL_W-1:0] vol;
  logic [PER_W-1:0] period;
  logic             restart;
  logic             step;
  logic             wave_bit;
  logic             muted;
  logic [VOL_W-1:0] sample_q;

  sqch_regs #(.PER_W(PER_W), .VOL_W(VOL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty(duty), .vol(vol), .period(period), .restart(restart)
  );

  sqch_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .period(period), .step(step)
  );

  sqch_seq u_seq (
    .clk(clk), .rst(rst), .adv(step), .restart(restart),
    .duty(duty), .wave_bit(wave_bit)
  );

  assign muted = (period < PER_W'(MUTE_MIN));

  always_ff @(posedge clk) begin
    if (rst)                  sample_q <= '0;
    else if (wave_bit && !muted) sample_q <= vol;
    else                      sample_q <= '0;
  end

  assign sample = sample_q;

  // R9: a short period silences the next sample
  a_r9_mute_silent: assert property (@(posedge clk) disable iff (rst)
    muted |=> (sample_q == '0));
  // R6: an audible high pattern bit emits the volume
  a_r6_volume_out: assert property (@(posedge clk) disable iff (rst)
    (!muted && wave_bit) |=> (sample_q == $past(vol)));
  // R6: a low pattern bit emits silence
  a_r6_low_bit: assert property (@(posedge clk) disable iff (rst)
    !wave_bit |=> (sample_q == '0));
endmodule

// File: tb/sim_sqch_top.sv
module sim_sqch_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] sample;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sqch_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample(sample)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Length of the next complete run of samples equal to val; -1 on timeout.
  task automatic run_len(input logic [3:0] val, output int len);
    int t = 0;
    len = 0;
    while (sample == val && t < 20000) begin @(negedge clk); t++; end
    while (sample != val && t < 20000) begin @(negedge clk); t++; end
    while (sample == val && t < 20000) begin @(negedge clk); t++; len++; end
    if (t >= 20000) len = -1;
  endtask

  task automatic t_reset();
    int nz = 0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(sample == 4'd0, "R1 reset sample", sample, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sample != 4'd0) nz++;
    end
    check(nz == 0, "R1 silent before programming", nz, 0);
  endtask

  // R7/R8: restart lands at the pending underflow, not a reloaded one
  task automatic t_restart_keeps_divider();
    int d = 0;
    wr(2'd0, 8'h8F);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);
    repeat (40) @(negedge clk);
    wr(2'd2, 8'd200);
    repeat (300) @(negedge clk);
    wr(2'd3, 8'd0);
    @(negedge clk);
    while (sample != 4'd15 && d < 2000) begin @(negedge clk); d++; end
    check(d > 60 && d < 160, "R7 R8 restart delay to first high", d, 100);
  endtask

  task automatic t_mute();
    int nz = 0;
    int d = 0;
    wr(2'd2, 8'd5);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sample != 4'd0) nz++;
    end
    check(nz == 0, "R9 period 5 silent", nz, 0);
    wr(2'd2, 8'd8);
    while (sample != 4'd15 && d < 400) begin @(negedge clk); d++; end
    check(d < 400, "R9 sequencer kept running, tone resumes", d, 0);
  endtask

  task automatic t_duty(input logic [1:0] sel, input int hi, input int lo);
    int l;
    wr(2'd0, {sel, 6'h0F});
    repeat (200) @(negedge clk);
    run_len(4'd15, l);
    check(l == hi, $sformatf("R5 duty %0d high run", sel), l, hi);
    run_len(4'd0, l);
    check(l == lo, $sformatf("R5 duty %0d low run", sel), l, lo);
  endtask

  task automatic t_volume_and_addr1();
    int l;
    wr(2'd0, 8'hB7);   // duty 2, bits 5:4 set, volume 7
    repeat (200) @(negedge clk);
    run_len(4'd7, l);
    check(l == 72, "R6 volume 7 run", l, 72);
    wr(2'd1, 8'hFF);
    repeat (200) @(negedge clk);
    run_len(4'd7, l);
    check(l == 72, "R2 address 1 ignored", l, 72);
  endtask

  task automatic t_period_81();
    int l;
    wr(2'd0, 8'h8F);
    wr(2'd2, 8'h81);
    wr(2'd3, 8'h00);
    run_len(4'd15, l);
    check(l == 1040, "R3 R4 period 0x81 high run", l, 1040);
    run_len(4'd0, l);
    check(l == 1040, "R3 R4 period 0x81 low run", l, 1040);
  endtask

  task automatic t_high_bits();
    int l;
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hF9);   // only bits 2:0 = 001 count
    run_len(4'd15, l);
    check(l == 2056, "R2 period high bits", l, 2056);
  endtask

  initial begin
    t_reset();
    t_restart_keeps_divider();
    t_mute();
    t_duty(2'd0, 18, 126);
    t_duty(2'd1, 36, 108);
    t_duty(2'd2, 72, 72);
    t_duty(2'd3, 108, 36);
    t_volume_and_addr1();
    t_period_81();
    t_high_bits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 180000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule